// File: doc/BRIEF.md
# Priority-Pool Bus Arbiter with QoS Ceiling

This block decides which of `N_HOSTS` requesting hosts (16 by default) owns a single shared slave port. Every host carries a programmable 2-bit priority and a QoS-follow bit. From these two settings the block derives an effective priority for each host. When the QoS-follow bit is clear, the programmed priority is used unchanged. When it is set, the host's live 2-bit QoS input is used, capped so that it never exceeds the programmed priority.

Requesting hosts that share an effective priority form a pool, and the highest non-empty pool wins. The pool level sets the tie-break rule. Level 0 and level 3 rotate round-robin, and each of these two levels keeps its own last-winner pointer. Levels 1 and 2 use a fixed order in which the lowest host index wins. The winner's effective priority is presented on `grant_prio` in the same cycle as the one-hot grant.

Configuration is written one host at a time through a small write port. A lock input blocks all such writes.

The control is a two-state machine:
- **ST_IDLE**: no owner.
- **ST_OWNED**: a host holds the grant.

It has three transitions:
- **ACQUIRE**: from ST_IDLE to ST_OWNED, when any request is present at a clock edge.
- **KEEP**: from ST_OWNED to ST_OWNED, while the owner still requests.
- **RELEASE**: from ST_OWNED to ST_IDLE, when the owner's request is low at an edge.

Top module: `pool_arbiter`

## Requirements
- R1: After reset, `grant` and `grant_prio` are 0, every host's priority and QoS-follow bit are 0, and both round-robin pointers point at host `N_HOSTS-1`, so the first level-0 search starts at host 0.
- R2: With its QoS-follow bit at 0, a host's effective priority equals its programmed priority, and `grant_prio` shows that value while the host holds the grant.
- R3: With its QoS-follow bit at 1, a host's effective priority is min(`qos_in[h]`, programmed priority), sampled in the arbitration cycle, and `grant_prio` shows that value.
- R4: A grant always goes to a requesting host whose effective priority is the highest among all requesters.
- R5: Within level 0 and level 3, the search starts at the host index just above that level's pointer and wraps around. The pointer is set to the winner only when its own level wins, and the two levels keep separate pointers.
- R6: Within level 1 and level 2, the requesting host with the lowest index wins.
- R7: While the granted host keeps its request high, `grant` and `grant_prio` stay unchanged, whatever other hosts request.
- R8: At the first clock edge where the owner's request is low, `grant` and `grant_prio` return to 0. At the following edge, a new arbitration is made if any request is present.
- R9: `grant` is one-hot or all zero, and `grant_prio` is 0 whenever `grant` is 0.
- R10: A write with `cfg_lock` high changes neither the priority nor the QoS-follow bit of any host.
- R11: A write with `cfg_we` high and `cfg_lock` low stores `cfg_prio` and `cfg_qos_en` for host `cfg_host`, and the new values are used from the next arbitration on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Write protection; while high, writes are dropped |
| cfg_host | input | $clog2(N_HOSTS) | Host index of the write |
| cfg_prio | input | 2 | Programmed priority (ceiling when QoS-follow is on) |
| cfg_qos_en | input | 1 | QoS-follow bit for the written host |
| req | input | N_HOSTS | Request lines, one per host |
| qos_in | input | N_HOSTS x 2 | Live QoS value per host |
| grant | output | N_HOSTS | One-hot grant, or 0 |
| grant_prio | output | 2 | Effective priority of the granted host |

## Verification
The RELEASE transition and the next ACQUIRE fall in adjacent cycles. The round-robin pointer update also coincides with a grant from its own level. The bench provokes both by dropping only the owner's request while other hosts, some of them in the same round-robin pool, keep theirs asserted. It then checks for exactly one empty cycle followed by a grant to the next host after the pointer. In an exhaustive sweep of all priority settings and request patterns on a 4-host build, pointer state carries over from trial to trial. A bench model tracks that state arithmetically, so a pointer that moves on the wrong level shows up in a later grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int PRIO_W     = 2;
    localparam int NUM_LEVELS = 1 << PRIO_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
    parameter int N_HOSTS = 16,
    localparam int IDX_W  = $clog2(N_HOSTS)
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       we,
    input  logic                                       lock,
    input  logic [IDX_W-1:0]                           idx,
    input  logic [arb_pkg::PRIO_W-1:0]                 prio_wr,
    input  logic                                       qen_wr,
    output logic [N_HOSTS-1:0][arb_pkg::PRIO_W-1:0]    prio_vec,
    output logic [N_HOSTS-1:0]                         qen_vec
);
    // Per-host storage, written one host per cycle, blocked by lock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_vec <= '0;
            qen_vec  <= '0;
        end else if (we && !lock) begin
            prio_vec[idx] <= prio_wr;
            qen_vec[idx]  <= qen_wr;
        end
    end
endmodule

// File: rtl/arb_eff_prio.sv
module arb_eff_prio #(
    parameter int N_HOSTS = 16
) (
    input  logic [N_HOSTS-1:0][arb_pkg::PRIO_W-1:0] prio_vec,
    input  logic [N_HOSTS-1:0]                      qen_vec,
    input  logic [N_HOSTS-1:0][arb_pkg::PRIO_W-1:0] qos_vec,
    output logic [N_HOSTS-1:0][arb_pkg::PRIO_W-1:0] eff_vec
);
    // Programmed value acts as a ceiling on the live QoS when following.
    for (genvar h = 0; h < N_HOSTS; h++) begin : g_host
        logic [arb_pkg::PRIO_W-1:0] capped;
        assign capped     = (qos_vec[h] < prio_vec[h]) ? qos_vec[h] : prio_vec[h];
        assign eff_vec[h] = qen_vec[h] ? capped : prio_vec[h];
    end
endmodule

// File: rtl/arb_pool_pick.sv
module arb_pool_pick #(
    parameter int N_HOSTS     = 16,
    parameter bit ROUND_ROBIN = 1'b0,
    localparam int IDX_W      = $clog2(N_HOSTS)
) (
    input  logic [N_HOSTS-1:0] mask,
    input  logic [IDX_W-1:0]   last,
    output logic               hit,
    output logic [IDX_W-1:0]   win
);
    assign hit = |mask;

    if (ROUND_ROBIN) begin : g_rr
        // Scan from last+N down to last+1 so the nearest candidate after
        // the pointer is assigned last and therefore wins.
        always_comb begin
            int cand;
            win = '0;
            for (int k = N_HOSTS; k >= 1; k--) begin
                cand = (int'(last) + k) % N_HOSTS;
                if (mask[cand]) win = IDX_W'(cand);
            end
        end
    end else begin : g_fixed
        // Lowest index wins: scan downward, keep the last match.
        always_comb begin
            win = '0;
            for (int k = N_HOSTS - 1; k >= 0; k--) begin
                if (mask[k]) win = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/pool_arbiter.sv
module pool_arbiter #(
    parameter int N_HOSTS = 16,
    localparam int IDX_W  = $clog2(N_HOSTS)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cfg_we,
    input  logic                                    cfg_lock,
    input  logic [IDX_W-1:0]                        cfg_host,
    input  logic [1:0]                              cfg_prio,
    input  logic                                    cfg_qos_en,
    input  logic [N_HOSTS-1:0]                      req,
    input  logic [N_HOSTS-1:0][1:0]                 qos_in,
    output logic [N_HOSTS-1:0]                      grant,
    output logic [1:0]                              grant_prio
);
    import arb_pkg::*;

    localparam int TOP_LVL = NUM_LEVELS - 1;

    logic [N_HOSTS-1:0][PRIO_W-1:0]     prio_vec;
    logic [N_HOSTS-1:0]                 qen_vec;
    logic [N_HOSTS-1:0][PRIO_W-1:0]     eff_vec;
    logic [NUM_LEVELS-1:0][N_HOSTS-1:0] lvl_mask;
    logic [NUM_LEVELS-1:0]              lvl_hit;
    logic [NUM_LEVELS-1:0][IDX_W-1:0]   lvl_win;
    logic [NUM_LEVELS-1:0][IDX_W-1:0]   rr_ptr;
    logic [PRIO_W-1:0]                  sel_lvl;
    logic [IDX_W-1:0]                   sel_idx;
    logic                               any_hit;
    logic                               owner_req;
    arb_state_e                         state_q, state_d;

    arb_cfg_regs #(.N_HOSTS(N_HOSTS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .lock     (cfg_lock),
        .idx      (cfg_host),
        .prio_wr  (cfg_prio),
        .qen_wr   (cfg_qos_en),
        .prio_vec (prio_vec),
        .qen_vec  (qen_vec)
    );

    arb_eff_prio #(.N_HOSTS(N_HOSTS)) u_eff (
        .prio_vec (prio_vec),
        .qen_vec  (qen_vec),
        .qos_vec  (qos_in),
        .eff_vec  (eff_vec)
    );

    // One pool picker per level; outer levels rotate, inner are fixed.
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        for (genvar h = 0; h < N_HOSTS; h++) begin : g_m
            assign lvl_mask[l][h] = req[h] && (eff_vec[h] == PRIO_W'(l));
        end
        arb_pool_pick #(
            .N_HOSTS     (N_HOSTS),
            .ROUND_ROBIN ((l == 0) || (l == TOP_LVL))
        ) u_pick (
            .mask (lvl_mask[l]),
            .last (rr_ptr[l]),
            .hit  (lvl_hit[l]),
            .win  (lvl_win[l])
        );
    end

    // Highest non-empty level wins.
    always_comb begin
        sel_lvl = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (lvl_hit[l]) sel_lvl = PRIO_W'(l);
        end
    end

    assign sel_idx   = lvl_win[sel_lvl];
    assign any_hit   = |lvl_hit;
    assign owner_req = |(grant & req);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: ACQUIRE, KEEP, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_hit)    state_d = ST_OWNED;
            ST_OWNED: if (!owner_req) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs and round-robin pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant      <= '0;
            grant_prio <= '0;
            for (int l = 0; l < NUM_LEVELS; l++) rr_ptr[l] <= IDX_W'(N_HOSTS - 1);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_hit) begin
                        grant      <= {{(N_HOSTS-1){1'b0}}, 1'b1} << sel_idx;
                        grant_prio <= sel_lvl;
                        if ((sel_lvl == '0) || (sel_lvl == PRIO_W'(TOP_LVL)))
                            rr_ptr[sel_lvl] <= sel_idx;
                    end
                end
                ST_OWNED: begin
                    if (!owner_req) begin
                        grant      <= '0;
                        grant_prio <= '0;
                    end
                end
                default: begin
                    grant      <= '0;
                    grant_prio <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_HOSTS = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_HOSTS-1:0]           req,
    input logic [N_HOSTS-1:0]           grant,
    input logic [1:0]                   grant_prio,
    input logic                         cfg_we,
    input logic                         cfg_lock,
    input logic [N_HOSTS-1:0][1:0]      prio_vec,
    input logic [N_HOSTS-1:0]           qen_vec
);
    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    idle_prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> (grant_prio == 2'd0));

    // R7
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & req)) |=> ($stable(grant) && $stable(grant_prio)));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !(|(grant & req))) |=> (grant == '0));

    // R4
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (req != '0)) |=> (|(grant & $past(req))));

    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_lock) |=> ($stable(prio_vec) && $stable(qen_vec)));
endmodule

bind pool_arbiter arb_checker #(.N_HOSTS(N_HOSTS)) u_arb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .grant      (grant),
    .grant_prio (grant_prio),
    .cfg_we     (cfg_we),
    .cfg_lock   (cfg_lock),
    .prio_vec   (prio_vec),
    .qen_vec    (qen_vec)
);

// File: tb/test_pool_arbiter.sv
`timescale 1ns/1ps
module test_pool_arbiter;
    localparam int N = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_lock = 1'b0;
    logic [1:0]       cfg_host = '0;
    logic [1:0]       cfg_prio = '0;
    logic             cfg_qos_en = 1'b0;
    logic [N-1:0]     req = '0;
    logic [N-1:0][1:0] qos_in = '0;
    logic [N-1:0]     grant;
    logic [1:0]       grant_prio;

    int n_checks = 0;
    int n_fail = 0;
    int m_prio [N];
    int m_qen  [N];
    int m_ptr  [4];

    always #4 clk = ~clk;

    pool_arbiter #(.N_HOSTS(N)) i_pool_arbiter (
        .clk, .rst_n, .cfg_we, .cfg_lock, .cfg_host, .cfg_prio, .cfg_qos_en,
        .req, .qos_in, .grant, .grant_prio
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Model of arbitration; advances its own pointer copy.
    task automatic model(input logic [N-1:0] r, input logic [2*N-1:0] qf,
                         output int g, output int gp);
        int eff [N];
        int best = -1;
        int win = -1;
        for (int i = 0; i < N; i++) begin
            int q = int'(qf[2*i +: 2]);
            eff[i] = (m_qen[i] != 0) ? ((q < m_prio[i]) ? q : m_prio[i]) : m_prio[i];
            if (r[i] && eff[i] > best) best = eff[i];
        end
        if (best < 0) begin
            g = 0; gp = 0;
            return;
        end
        if (best == 0 || best == 3) begin
            for (int k = 1; k <= N; k++) begin
                int c = (m_ptr[best] + k) % N;
                if (win < 0 && r[c] && eff[c] == best) win = c;
            end
            m_ptr[best] = win;
        end else begin
            for (int i = N - 1; i >= 0; i--) if (r[i] && eff[i] == best) win = i;
        end
        g = 1 << win;
        gp = best;
    endtask

    task automatic write_cfg(input int h, input int p, input int qe);
        cfg_we = 1'b1; cfg_host = 2'(h); cfg_prio = 2'(p); cfg_qos_en = qe[0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (!cfg_lock) begin
            m_prio[h] = p;
            m_qen[h] = qe;
        end
    endtask

    // Grant in the cycle after the request, then release.
    task automatic trial(input logic [N-1:0] r, input logic [2*N-1:0] qf,
                         input string gtag, input string ptag);
        int g, gp;
        req = r; qos_in = qf;
        model(r, qf, g, gp);
        @(negedge clk);
        check(gtag, "grant", int'(grant), g);
        check(ptag, "grant_prio", int'(grant_prio), gp);
        req = '0;
        @(negedge clk);
        check("R8", "grant after release", int'(grant), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int g, gp;
        for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_qen[i] = 0; end
        for (int l = 0; l < 4; l++) m_ptr[l] = N - 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1", "grant", int'(grant), 0);
        check("R1", "grant_prio", int'(grant_prio), 0);
        trial(4'hF, '0, "R1", "R1");

        // R2 R4 R5 R6 R11: all priority settings, all request patterns
        for (int c = 0; c < 256; c++) begin
            for (int h = 0; h < N; h++) write_cfg(h, (c >> (2*h)) & 3, 0);
            for (int r = 0; r < 16; r++) begin
                int top = -1;
                for (int h = 0; h < N; h++)
                    if (r[h] && m_prio[h] > top) top = m_prio[h];
                if (r == 0)
                    trial(4'(r), '0, "R9", "R9");
                else if (top == 1 || top == 2)
                    trial(4'(r), '0, "R6", "R2");
                else
                    trial(4'(r), '0, "R5", "R2");
            end
        end

        // R3: QoS follow with ceilings, every QoS pattern
        for (int c = 0; c < 2; c++) begin
            for (int h = 0; h < N; h++) write_cfg(h, (c == 0) ? 3 - h : 3, 1);
            for (int q = 0; q < 256; q++) trial(4'hF, 8'(q), "R4", "R3");
        end

        // R7 R8: hold, release, re-arbitration
        for (int h = 0; h < N; h++) write_cfg(h, 0, 0);
        req = 4'b0001;
        model(4'b0001, '0, g, gp);
        @(negedge clk);
        check("R7", "initial grant", int'(grant), g);
        req = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7", "held grant", int'(grant), 1);
        end
        req = 4'b1110;
        model(4'b1110, '0, g, gp);
        @(negedge clk);
        check("R8", "empty cycle", int'(grant), 0);
        @(negedge clk);
        check("R8", "re-arbitrated grant", int'(grant), g);
        req = '0;
        @(negedge clk);

        // R10: locked write ignored, visible through grant_prio
        write_cfg(2, 2, 0);
        cfg_lock = 1'b1;
        write_cfg(2, 3, 0);
        cfg_lock = 1'b0;
        trial(4'b0100, '0, "R10", "R10");
        write_cfg(2, 1, 0);
        trial(4'b0100, '0, "R11", "R11");

        summary();
    end
endmodule